// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block turns a single core-supply reset request into four ordered, active-low reset outputs. The request comes from an analog supply monitor and stands for power-on, brownout or loss of regulation. Whenever that request is active, every output is pulled low at once, without waiting for a clock edge. When the request goes away, the block releases the outputs one after another on the slow clock.

The order of release is fixed. The backup-domain reset goes first, once the request has passed a two-flop synchronizer. The peripheral and processor resets follow after a short startup delay. The external reset pin is released on its own, after a pulse whose length is set by a 4-bit field in a mode register. A small register port lets software read and write that length field. Software can use it to stretch the pin pulse for slow external parts while the pin is still held low. The same port reads a cause field, which is written at the moment the processor leaves reset.

Top module: `por_seq_ctrl`

## Requirements
- R1: While `vdd_rst_n` is low, all four reset outputs are low. A falling `vdd_rst_n` forces them low before any clock edge.
- R2: After `vdd_rst_n` rises, `backup_rst_n` goes high on the second rising clock edge.
- R3: `periph_rst_n` and `proc_rst_n` go high together, exactly 2 clock cycles after `backup_rst_n` goes high.
- R4: `ext_rst_n` goes high 2^(L+1) cycles after `backup_rst_n` goes high, where L is the length field. After a supply reset L is 0, which gives a 2-cycle pulse.
- R5: The mode register is selected by `reg_sel`=0 and holds L in bits [3:0]. It reads 0 after every supply reset. A write stores only bits [3:0], and the upper bits read as 0.
- R6: A length written after the backup release, while `ext_rst_n` is still low, sets the pulse of the sequence in progress. Once `ext_rst_n` is high, later writes to the length do not pull it low again.
- R7: The status register is selected by `reg_sel`=1 and holds the cause in bits [2:0]. It reads 0x7 (pending) until the cycle in which the processor reset is released. From that cycle on it reads 0x0 (supply reset).
- R8: Writes to the status register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow clock that runs the sequencer |
| vdd_rst_n | input | 1 | Core-supply reset request from the supply monitor, active low |
| reg_sel | input | 1 | Register select: 0 selects mode, 1 selects status |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register, combinational |
| backup_rst_n | output | 1 | Backup-domain reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| proc_rst_n | output | 1 | Processor reset, active low |
| ext_rst_n | output | 1 | External reset pin drive, active low |

## Verification
The sequencer is run through three supply-reset releases. The first keeps the default length. The second and third program lengths of 3 and 5 during the pin pulse. The default-length run shows the pin and the processor reset rising in the same cycle, so an error in the startup delay or the length decoding shows up as a misordered or mistimed event. The two programmed runs give 16-cycle and 64-cycle pulses, which separate a live use of the written length from a wrong shift amount or an off-by-one. Between runs the bench drops the supply request between clock edges and writes to both registers, checking that the outputs fall without a clock, that the mode field clears and that the status field cannot be overwritten.

// File: rtl/por_pkg.sv
// Package: shared types for the power-on reset sequencer.
// Assumes: one-bit register select on the access port.
package por_pkg;
    typedef enum logic {
        SEL_MODE   = 1'b0,
        SEL_STATUS = 1'b1
    } por_sel_e;
endpackage

// File: rtl/por_sync.sv
// Module: por_sync
// Purpose: brings the core-supply reset request into the slow-clock domain.
// The clear is asynchronous: a low input clears every stage at once.
// The release is synchronous and takes STAGES rising edges to pass through.
// Assumes: arst_n may change at any time relative to clk.
module por_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic sync_n
);
    logic [STAGES-1:0] stage_q;

    // Shift a one through the chain; the supply request clears it at once.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], 1'b1};
        end
    end

    assign sync_n = stage_q[STAGES-1];
endmodule

// File: rtl/por_timer.sv
// Module: por_timer
// Purpose: counts slow-clock cycles from the backup release and sets two
// sticky flags. One flag marks the end of the startup delay (processor and
// peripherals), the other the end of the pin pulse of 2^(len+1) cycles.
// Assumes: rel_n is the synchronized supply release and serves as the
// active-low synchronous reset; len may change while the count runs.
module por_timer #(
    parameter int LEN_W       = 4,
    parameter int STARTUP_CYC = 2,
    parameter int CNT_W       = (1 << LEN_W) + 1
) (
    input  logic             clk,
    input  logic             rel_n,
    input  logic [LEN_W-1:0] len,
    output logic             proc_done,
    output logic             ext_done,
    output logic             proc_fire
);
    localparam logic [CNT_W:0] START_V = STARTUP_CYC[CNT_W:0];
    localparam logic [CNT_W:0] ONE_V   = {{CNT_W{1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_nxt;
    logic [CNT_W:0]   lim;
    logic [LEN_W:0]   shift_amt;
    logic             ext_fire;

    // Next count value and the two release conditions.
    always_comb begin
        cnt_nxt   = {1'b0, cnt_q} + ONE_V;
        shift_amt = {1'b0, len} + {{LEN_W{1'b0}}, 1'b1};
        lim       = ONE_V << shift_amt;
        proc_fire = !proc_done && (cnt_nxt >= START_V);
        ext_fire  = !ext_done && (cnt_nxt >= lim);
    end

    // Cycles since the backup release, held at its maximum.
    always_ff @(posedge clk) begin
        if (!rel_n) begin
            cnt_q <= '0;
        end else if (cnt_q != {CNT_W{1'b1}}) begin
            cnt_q <= cnt_nxt[CNT_W-1:0];
        end
    end

    // Sticky release flags, cleared only by a new supply reset.
    always_ff @(posedge clk) begin
        if (!rel_n) begin
            proc_done <= 1'b0;
            ext_done  <= 1'b0;
        end else begin
            proc_done <= proc_done | proc_fire;
            ext_done  <= ext_done | ext_fire;
        end
    end

    AST_PROC_DELAY: assert property (@(posedge clk) disable iff (!rel_n)
        $rose(proc_done) |-> ({1'b0, cnt_q} == START_V)); // R3
    AST_EXT_DELAY: assert property (@(posedge clk) disable iff (!rel_n)
        $rose(ext_done) |-> ({1'b0, cnt_q} >= $past(lim))); // R4
    AST_PROC_STICKY: assert property (@(posedge clk) disable iff (!rel_n)
        proc_done |=> proc_done); // R3
    AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rel_n)
        ext_done |=> ext_done); // R6
endmodule

// File: rtl/por_regs.sv
// Module: por_regs
// Purpose: mode register (pin pulse length) and status register (reset
// cause), with a combinational read mux.
// Assumes: rel_n is low for the whole supply reset and clears both
// registers; proc_fire is high for exactly one cycle, at the processor release.
module por_regs
    import por_pkg::*;
#(
    parameter int              LEN_W        = 4,
    parameter int              RTYP_W       = 3,
    parameter int              DATA_W       = 8,
    parameter logic [RTYP_W-1:0] RTYP_GENERAL = '0
) (
    input  logic              clk,
    input  logic              rel_n,
    input  logic              sel,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              proc_fire,
    output logic [DATA_W-1:0] rdata,
    output logic [LEN_W-1:0]  len
);
    localparam logic [RTYP_W-1:0] RTYP_PENDING = '1;

    logic [LEN_W-1:0]  mode_q;
    logic [RTYP_W-1:0] status_q;

    // Mode register: cleared by a supply reset, written by software.
    always_ff @(posedge clk) begin
        if (!rel_n) begin
            mode_q <= '0;
        end else if (we && (sel == SEL_MODE)) begin
            mode_q <= wdata[LEN_W-1:0];
        end
    end

    // Status register: pending during reset, cause captured at processor release.
    always_ff @(posedge clk) begin
        if (!rel_n) begin
            status_q <= RTYP_PENDING;
        end else if (proc_fire) begin
            status_q <= RTYP_GENERAL;
        end
    end

    // Read mux, zero-extended to the port width.
    always_comb begin
        rdata = '0;
        if (sel == SEL_MODE) begin
            rdata[LEN_W-1:0] = mode_q;
        end else begin
            rdata[RTYP_W-1:0] = status_q;
        end
    end

    assign len = mode_q;

    AST_STATUS_LATCH: assert property (@(posedge clk) disable iff (!rel_n)
        proc_fire |=> (status_q == RTYP_GENERAL)); // R7
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rel_n)
        (status_q == RTYP_GENERAL) |=> (status_q == RTYP_GENERAL)); // R8
    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rel_n)
        !we |=> $stable(mode_q)); // R5
endmodule

// File: rtl/por_seq_ctrl.sv
// Module: por_seq_ctrl (top)
// Purpose: power-on reset sequencer. Synchronizes the core-supply reset
// request, releases backup, then peripheral and processor, then the pin
// reset, and exposes the mode and status registers.
// Assumes: clk_slow runs whenever vdd_rst_n is high. The synchronized
// request is the synchronous active-low reset of all internal state.
// Outputs are gated with it so that they drop without a clock edge.
module por_seq_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int LEN_W       = 4,
    parameter int STARTUP_CYC = 2,
    parameter int RTYP_W      = 3,
    parameter int DATA_W      = 8
) (
    input  logic              clk_slow,
    input  logic              vdd_rst_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              backup_rst_n,
    output logic              periph_rst_n,
    output logic              proc_rst_n,
    output logic              ext_rst_n
);
    localparam int CNT_W = (1 << LEN_W) + 1;

    logic             rel_n;
    logic             proc_done;
    logic             ext_done;
    logic             proc_fire;
    logic [LEN_W-1:0] len;

    por_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk_slow),
        .arst_n (vdd_rst_n),
        .sync_n (rel_n)
    );

    por_timer #(
        .LEN_W       (LEN_W),
        .STARTUP_CYC (STARTUP_CYC),
        .CNT_W       (CNT_W)
    ) u_timer (
        .clk       (clk_slow),
        .rel_n     (rel_n),
        .len       (len),
        .proc_done (proc_done),
        .ext_done  (ext_done),
        .proc_fire (proc_fire)
    );

    por_regs #(
        .LEN_W        (LEN_W),
        .RTYP_W       (RTYP_W),
        .DATA_W       (DATA_W),
        .RTYP_GENERAL ('0)
    ) u_regs (
        .clk       (clk_slow),
        .rel_n     (rel_n),
        .sel       (reg_sel),
        .we        (reg_we),
        .wdata     (reg_wdata),
        .proc_fire (proc_fire),
        .rdata     (reg_rdata),
        .len       (len)
    );

    // Output gating: the asynchronous clear of the synchronizer drops every output.
    always_comb begin
        backup_rst_n = rel_n;
        periph_rst_n = rel_n & proc_done;
        proc_rst_n   = rel_n & proc_done;
        ext_rst_n    = rel_n & ext_done;
    end

    AST_BACKUP_FIRST: assert property (@(posedge clk_slow) disable iff (!vdd_rst_n)
        $rose(proc_rst_n) |-> $past(backup_rst_n)); // R3
endmodule

// File: tb/por_seq_ctrl_tb.sv
`timescale 1ns/1ps
module por_seq_ctrl_tb;
    logic       clk = 1'b0;
    logic       vdd_rst_n = 1'b0;
    logic       reg_sel = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       backup_rst_n, periph_rst_n, proc_rst_n, ext_rst_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int    id;
        int    at;
        string req;
    } exp_t;
    exp_t exp_q[$];
    string out_name[4] = '{"backup", "periph", "proc", "ext"};

    por_seq_ctrl u_dut (
        .clk_slow     (clk),
        .vdd_rst_n    (vdd_rst_n),
        .reg_sel      (reg_sel),
        .reg_we       (reg_we),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .backup_rst_n (backup_rst_n),
        .periph_rst_n (periph_rst_n),
        .proc_rst_n   (proc_rst_n),
        .ext_rst_n    (ext_rst_n)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Monitor: each rising output pops the next expected event and compares.
    logic [3:0] prev_out = 4'b0000;
    always @(negedge clk) begin
        logic [3:0] cur;
        cur = {backup_rst_n, periph_rst_n, proc_rst_n, ext_rst_n};
        for (int i = 0; i < 4; i++) begin
            if (cur[3-i] && !prev_out[3-i]) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, {"unexpected rise of ", out_name[i]}, cyc, -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(e.id == i, {e.req, " order"}, i, e.id);
                    chk(e.at == cyc, {e.req, " ", out_name[i], " cycle"}, cyc, e.at);
                end
            end
        end
        prev_out = cur;
    end

    task automatic read_reg(input bit sel, output int val);
        reg_sel = sel;
        #0.5;
        val = int'(reg_rdata);
    endtask

    task automatic write_reg(input bit sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // Driver: release the supply request and push the expected events.
    task automatic release_seq(input bit do_wr, input int len);
        int n, v, ext_at, eff;
        eff = do_wr ? len : 0;
        @(negedge clk);
        vdd_rst_n = 1'b1;
        n = cyc;
        ext_at = n + 2 + (1 << (eff + 1));
        exp_q.push_back('{0, n + 2, "R2"});
        exp_q.push_back('{1, n + 4, "R3"});
        exp_q.push_back('{2, n + 4, "R3"});
        exp_q.push_back('{3, ext_at, do_wr ? "R6" : "R4"});
        @(negedge clk); @(negedge clk);
        if (do_wr) begin
            reg_sel = 1'b0; reg_wdata = 8'(len); reg_we = 1'b1;
        end
        @(negedge clk);
        reg_we = 1'b0;
        read_reg(1'b1, v);
        chk(v == 7, "R7 pending before processor release", v, 7);
        @(negedge clk);
        read_reg(1'b1, v);
        chk(v == 0, "R7 cause at processor release", v, 0);
        while (cyc < ext_at + 2) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all release events seen", exp_q.size(), 0);
    endtask

    task automatic drop_supply();
        int v;
        @(negedge clk);
        #1.0;
        vdd_rst_n = 1'b0;
        #0.2;
        v = {backup_rst_n, periph_rst_n, proc_rst_n, ext_rst_n};
        chk(v == 0, "R1 outputs low without clock edge", v, 0);
        repeat (3) @(negedge clk);
        read_reg(1'b0, v);
        chk(v == 0, "R5 mode cleared by supply reset", v, 0);
        read_reg(1'b1, v);
        chk(v == 7, "R7 pending during supply reset", v, 7);
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        v = {backup_rst_n, periph_rst_n, proc_rst_n, ext_rst_n};
        chk(v == 0, "R1 reset state outputs", v, 0);
        read_reg(1'b0, v);
        chk(v == 0, "R5 mode at reset", v, 0);
        read_reg(1'b1, v);
        chk(v == 7, "R7 status at reset", v, 7);

        release_seq(1'b0, 0);
        write_reg(1'b0, 8'hF3);
        read_reg(1'b0, v);
        chk(v == 3, "R5 mode readback upper bits zero", v, 3);
        chk(ext_rst_n == 1'b1, "R6 pin stays released after mode write", ext_rst_n, 1);
        write_reg(1'b1, 8'h05);
        read_reg(1'b1, v);
        chk(v == 0, "R8 status write ignored", v, 0);

        drop_supply();
        release_seq(1'b1, 3);
        write_reg(1'b0, 8'h00);
        @(negedge clk);
        chk(ext_rst_n == 1'b1, "R6 pin stays released after shorter length", ext_rst_n, 1);

        drop_supply();
        release_seq(1'b1, 5);
        v = {backup_rst_n, periph_rst_n, proc_rst_n, ext_rst_n};
        chk(v == 15, "R4 all outputs high at end", v, 15);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule